// File: doc/BRIEF.md
# Trigger Mode Tracker with EOI Message Forwarding

This block lives on the processor side of an interrupt controller. It holds one trigger-mode flag for each interrupt vector. Each time an interrupt is accepted, the flag for that vector is overwritten: a level-triggered delivery sets it and an edge-triggered delivery clears it.

When software signals end-of-interrupt for the vector it has just serviced, the block looks up that flag. If the flag is set, the originating redirection unit is still waiting for an acknowledgement before it may raise the same line again. The block therefore queues an EOI message carrying the vector and presents it on a valid/ready output. If the flag is clear, the end-of-interrupt is absorbed locally and nothing leaves the block.

A debug port reads the whole flag array as 32-bit words, one word at a time.

Top module: `tmr_eoi_tracker`

## Requirements
- R1: After reset every trigger-mode flag reads 0 through the debug port and `msg_valid` is low.
- R2: An accept with `acc_level`=1 sets the flag of `acc_vector`, and the new value is visible on the cycle after the accept.
- R3: An accept with `acc_level`=0 clears the flag of `acc_vector`, and the new value is visible on the cycle after the accept.
- R4: A software EOI whose vector has its flag at 1 causes a message carrying that vector. When the queue is empty, `msg_valid` rises on the cycle after the strobe.
- R5: A software EOI whose vector has its flag at 0 produces no message and leaves the queue unchanged.
- R6: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high on the next cycle and `msg_vector` is unchanged.
- R7: Up to 4 forwarded EOIs are held while the output is stalled. They are delivered in the order their strobes arrived.
- R8: With `dbg_sel`=k, `dbg_word` bit j shows the flag of vector 32*k+j, for k in 0..7 and j in 0..31.
- R9: When an accept and a software EOI for the same vector fall in the same cycle, the EOI decision uses the flag value held before that accept.
- R10: An accept changes only the flag of its own vector; all other flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An interrupt is accepted this cycle |
| acc_vector | input | 8 | Vector of the accepted interrupt |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| eoi_strobe | input | 1 | Software end-of-interrupt this cycle |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | An EOI message is offered |
| msg_vector | output | 8 | Vector carried by the offered message |
| msg_ready | input | 1 | Receiver takes the message this cycle |
| dbg_sel | input | 3 | Debug word index |
| dbg_word | output | 32 | 32 trigger-mode flags of the selected word |

## Verification
The assertions assume that software never forwards an EOI into a full queue. In other words, no more than four level-type EOIs are ever outstanding at once. The overflow property depends on this assumption and does not enforce it. The stimulus respects the limit by stalling the receiver for at most four forwarded EOIs and then draining the queue before it issues more. Accept and EOI vectors are always driven to known values whenever their strobes are high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_VECTORS = 256;
    localparam int TMR_VEC_W   = $clog2(TMR_VECTORS);
    localparam int DBG_WORD_W  = 32;
    localparam int DBG_WORDS   = TMR_VECTORS / DBG_WORD_W;
    localparam int DBG_SEL_W   = $clog2(DBG_WORDS);
    localparam int EOI_QDEPTH  = 4;

    typedef struct packed {
        logic                 valid;
        logic [TMR_VEC_W-1:0] vector;
        logic                 level;
    } accept_t;

    typedef struct packed {
        logic                 valid;
        logic [TMR_VEC_W-1:0] vector;
    } eoi_t;
endpackage

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_VEC = TMR_VECTORS,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  accept_t            acc,
    input  logic [VEC_W-1:0]   look_vector,
    output logic               look_bit,
    output logic [NUM_VEC-1:0] bits
);
    logic [NUM_VEC-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (acc.valid) begin
            bits_q[acc.vector] <= acc.level;
        end
    end

    // Lookup sees the value before any same-cycle update.
    assign look_bit = bits_q[look_vector];
    assign bits     = bits_q;
endmodule

// File: rtl/tmr_dbg_mux.sv
module tmr_dbg_mux #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int SEL_W   = $clog2(NUM_VEC / WORD_W)
) (
    input  logic [NUM_VEC-1:0] bits,
    input  logic [SEL_W-1:0]   sel,
    output logic [WORD_W-1:0]  word
);
    localparam int WORDS = NUM_VEC / WORD_W;

    logic [WORD_W-1:0] slice [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slice
        assign slice[w] = bits[w*WORD_W +: WORD_W];
    end

    assign word = slice[sel];
endmodule

// File: rtl/eoi_fifo.sv
module eoi_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;
    logic             do_pop, do_push;

    assign out_valid = (count_q != '0);
    assign out_data  = mem[rd_q];
    assign do_pop    = out_valid && out_ready;
    assign do_push   = push && ((count_q != CNT_W'(DEPTH)) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= push_data;
                wr_q      <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/tmr_eoi_tracker.sv
module tmr_eoi_tracker
    import tmr_pkg::*;
#(
    parameter int NUM_VEC = TMR_VECTORS,
    parameter int VEC_W   = $clog2(NUM_VEC),
    parameter int WORD_W  = DBG_WORD_W,
    parameter int SEL_W   = $clog2(NUM_VEC / WORD_W),
    parameter int QDEPTH  = EOI_QDEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [VEC_W-1:0]  acc_vector,
    input  logic              acc_level,
    input  logic              eoi_strobe,
    input  logic [VEC_W-1:0]  eoi_vector,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vector,
    input  logic              msg_ready,
    input  logic [SEL_W-1:0]  dbg_sel,
    output logic [WORD_W-1:0] dbg_word
);
    accept_t            acc;
    eoi_t               eoi;
    logic               eoi_level;
    logic [NUM_VEC-1:0] tmr_bits;

    assign acc = '{valid: acc_valid, vector: acc_vector, level: acc_level};
    assign eoi = '{valid: eoi_strobe, vector: eoi_vector};

    tmr_bank #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .look_vector (eoi.vector),
        .look_bit    (eoi_level),
        .bits        (tmr_bits)
    );

    eoi_fifo #(.DEPTH(QDEPTH), .DW(VEC_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (eoi.valid && eoi_level),
        .push_data (eoi.vector),
        .out_valid (msg_valid),
        .out_data  (msg_vector),
        .out_ready (msg_ready)
    );

    tmr_dbg_mux #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_dbg (
        .bits (tmr_bits),
        .sel  (dbg_sel),
        .word (dbg_word)
    );
endmodule

// File: rtl/tmr_eoi_checker.sv
module tmr_eoi_checker #(
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = 8,
    parameter int QDEPTH  = 4,
    parameter int CNT_W   = $clog2(QDEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic [VEC_W-1:0]   acc_vector,
    input logic               acc_level,
    input logic               eoi_strobe,
    input logic [VEC_W-1:0]   eoi_vector,
    input logic               msg_valid,
    input logic [VEC_W-1:0]   msg_vector,
    input logic               msg_ready,
    input logic [NUM_VEC-1:0] tmr_bits,
    input logic [CNT_W-1:0]   q_count
);
    // R1: reset clears the flags and the queue
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (tmr_bits == '0) && !msg_valid);

    assert_level_sets_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_level |=> tmr_bits[$past(acc_vector)]);

    assert_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_level |=> !tmr_bits[$past(acc_vector)]);

    assert_forward_R4: assert property (@(posedge clk) disable iff (rst)
        eoi_strobe && tmr_bits[eoi_vector] |=> msg_valid);

    assert_absorb_R5: assert property (@(posedge clk) disable iff (rst)
        eoi_strobe && !tmr_bits[eoi_vector] && !(msg_valid && msg_ready)
        |=> q_count == $past(q_count));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(QDEPTH));
endmodule

bind tmr_eoi_tracker tmr_eoi_checker #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .QDEPTH(QDEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_vector (acc_vector),
    .acc_level  (acc_level),
    .eoi_strobe (eoi_strobe),
    .eoi_vector (eoi_vector),
    .msg_valid  (msg_valid),
    .msg_vector (msg_vector),
    .msg_ready  (msg_ready),
    .tmr_bits   (tmr_bits),
    .q_count    (u_fifo.count_q)
);

// File: tb/tb_tmr_eoi_tracker.sv
module tb_tmr_eoi_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_level = 1'b0;
    logic       eoi_strobe = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic       msg_valid;
    logic [7:0] msg_vector;
    logic       msg_ready = 1'b0;
    logic [2:0] dbg_sel = '0;
    logic [31:0] dbg_word;

    int checks = 0;
    int errors = 0;
    logic model [256];
    logic [7:0] sb [$];

    always #4 clk = ~clk;

    tmr_eoi_tracker dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .eoi_strobe(eoi_strobe), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_ready(msg_ready),
        .dbg_sel(dbg_sel), .dbg_word(dbg_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: at each falling edge, a handshake about to complete is compared with the scoreboard.
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected message", {24'h0, msg_vector}, 32'h0);
            end else begin
                logic [7:0] exp;
                exp = sb.pop_front();
                check(msg_vector == exp, "R4/R7 message vector", {24'h0, msg_vector}, {24'h0, exp});
            end
        end
    end

    // Driver: one cycle with optional accept and EOI; expectations are taken from the model first (R9).
    task automatic drive(input bit a, input logic [7:0] av, input bit lvl,
                         input bit e, input logic [7:0] ev);
        @(posedge clk); #1;
        acc_valid = a; acc_vector = av; acc_level = lvl;
        eoi_strobe = e; eoi_vector = ev;
        if (e && model[ev]) sb.push_back(ev);
        if (a) model[av] = lvl;
        @(posedge clk); #1;
        acc_valid = 1'b0; eoi_strobe = 1'b0;
    endtask

    task automatic check_word(input int k, input string req);
        logic [31:0] exp;
        for (int j = 0; j < 32; j++) exp[j] = model[32*k + j];
        dbg_sel = 3'(k);
        #1;
        check(dbg_word == exp, req, dbg_word, exp);
    endtask

    task automatic drain();
        msg_ready = 1'b1;
        for (int i = 0; i < 20 && sb.size() != 0; i++) @(posedge clk);
        @(posedge clk); #1;
        check(sb.size() == 0, "R7 queue drained", 32'(sb.size()), 32'h0);
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!msg_valid, "R1 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
        for (int k = 0; k < 8; k++) check_word(k, "R1 debug word after reset");

        // R2 / R8: level accept on 0x99 sets bit 25 of word 4
        drive(1, 8'h99, 1, 0, 8'h0);
        check_word(4, "R2 level sets flag");
        // R3: edge accept clears it
        drive(1, 8'h99, 0, 0, 8'h0);
        check_word(4, "R3 edge clears flag");

        // R8 / R10: word boundaries, neighbours untouched
        drive(1, 8'd0, 1, 0, 8'h0);
        drive(1, 8'd31, 1, 0, 8'h0);
        drive(1, 8'd32, 1, 0, 8'h0);
        drive(1, 8'd255, 1, 0, 8'h0);
        drive(1, 8'd1, 0, 0, 8'h0);
        for (int k = 0; k < 8; k++) check_word(k, "R8 R10 debug word map");

        // R5: EOI for an edge vector is absorbed
        msg_ready = 1'b1;
        drive(0, 8'h0, 0, 1, 8'h99);
        @(negedge clk);
        check(!msg_valid, "R5 no message for edge vector", {31'h0, msg_valid}, 32'h0);

        // R4: EOI for a level vector is forwarded next cycle
        drive(0, 8'h0, 0, 1, 8'd31);
        check(msg_valid, "R4 message after level EOI", {31'h0, msg_valid}, 32'h1);
        drain();

        // R6 / R7: stall with four queued EOIs
        msg_ready = 1'b0;
        drive(0, 8'h0, 0, 1, 8'd255);
        drive(0, 8'h0, 0, 1, 8'd0);
        drive(0, 8'h0, 0, 1, 8'd32);
        drive(0, 8'h0, 0, 1, 8'd31);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(msg_valid && msg_vector == 8'd255, "R6 held while stalled",
                  {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'd255});
        end
        drain();

        // R9: same-cycle accept and EOI on one vector use the old flag
        drive(1, 8'd5, 1, 1, 8'd5);
        @(negedge clk);
        check(!msg_valid, "R9 old flag 0 wins", {31'h0, msg_valid}, 32'h0);
        drive(1, 8'd5, 0, 1, 8'd5);
        check(msg_valid && msg_vector == 8'd5, "R9 old flag 1 wins",
              {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'd5});
        drain();
        check_word(0, "R9 flag updated after same-cycle accept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule